// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent resolved branch outcomes across the whole program. It also keeps a tagless table of small saturating counters. The table index is formed from the history and a few low-order word-address bits of the branch PC. A parameter chooses how the two are combined: placed side by side (concatenation), or folded together with XOR (gshare style). With zero history bits the block reduces to a plain PC-indexed counter table.

The front end presents a PC on the lookup side. In the same cycle it receives a taken/not-taken guess and the history value the guess was based on. When the branch resolves later, the back end sends the PC, the real outcome and that captured history on the update side. The addressed counter moves one step toward the outcome, and the outcome is shifted into the global history.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value 2^(CTR_W-1)-1 and the history is zero, so every lookup predicts not taken.
- R2: Each cycle with `up_valid` high shifts the history left by one and places `up_taken` in bit 0 (1 = taken). Without `up_valid` the history holds its value.
- R3: `lk_hist` shows the current global history in the same cycle as the lookup, so it can be returned later with the update.
- R4: With MODE = IDX_CONCAT the table index is {history, pc[ADDR_W+1:2]}. With the defaults (2 history bits, 4 address bits) this gives a 6-bit index and 64 entries.
- R5: With MODE = IDX_XOR the table index is pc[ADDR_W+1:2] XOR the zero-extended history, so the table has 2^ADDR_W entries.
- R6: A taken update raises the addressed counter by one and holds it at 2^CTR_W-1.
- R7: A not-taken update lowers the addressed counter by one and holds it at 0.
- R8: The prediction is taken exactly when the indexed counter is at least 2^(CTR_W-1).
- R9: The update addresses the table with `up_hist`, not with the current history.
- R10: When a lookup and an update address the same entry in the same cycle, the lookup returns the value from before the update.
- R11: PC bits 1 and 0 play no part in the index.
- R12: There are no tags. Two PCs that differ only above bit ADDR_W+1 share an entry and train each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_taken | output | 1 | Prediction, 1 = taken |
| lk_hist | output | GH_W | Global history used for this prediction |
| up_valid | input | 1 | Resolved-branch strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | GH_W | History captured when that branch was predicted |

## Verification
A lookup and an update can fall in the same cycle, and they can address the same counter. The bench provokes this by giving both sides the same PC while `up_hist` equals the live history. It expects the lookup to show the counter value from before the clock edge, then expects the trained value on the next lookup. The same collision also happens at random during a long mixed run. There, a reference model of counters and history judges the concatenating instance and the XOR-hashing instance side by side.

// File: rtl/bp_pkg.sv
package bp_pkg;
   typedef enum logic {
      IDX_CONCAT = 1'b0,
      IDX_XOR    = 1'b1
   } idx_mode_e;
endpackage

// File: rtl/bp_index.sv
module bp_index import bp_pkg::*; #(
   parameter int        PC_W   = 32,
   parameter int        HIST_W = 2,
   parameter int        ADDR_W = 4,
   parameter int        GH_W   = 2,
   parameter int        IDX_W  = 6,
   parameter idx_mode_e MODE   = IDX_CONCAT
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [GH_W-1:0]  hist,
   output logic [IDX_W-1:0] idx
);
   logic [ADDR_W-1:0] word_bits;
   logic              unused_pc_bits;

   assign word_bits      = pc[ADDR_W+1:2];
   assign unused_pc_bits = ^{pc[PC_W-1:ADDR_W+2], pc[1:0]};

   generate
      if (HIST_W == 0) begin : g_pc_only
         logic unused_hist;
         assign unused_hist = ^hist;
         assign idx         = IDX_W'(word_bits);
      end else if (MODE == IDX_CONCAT) begin : g_concat
         assign idx = {hist[HIST_W-1:0], word_bits};
      end else begin : g_xor
         assign idx = word_bits ^ ADDR_W'(hist[HIST_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
   parameter int HIST_W = 2,
   parameter int GH_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_en,
   input  logic            bit_in,
   output logic [GH_W-1:0] hist
);
   generate
      if (HIST_W == 0) begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, shift_en, bit_in};
         assign hist      = '0;
      end else if (HIST_W == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist <= '0;
            else if (shift_en) hist <= bit_in;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist <= '0;
            else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
         end
      end
   endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
   parameter int IDX_W = 6,
   parameter int CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken,
   output logic [CTR_W-1:0] wr_old
);
   localparam int             DEPTH   = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W-1)) - 1);

   logic [CTR_W-1:0] ctr [DEPTH];
   logic [CTR_W-1:0] nxt;

   assign rd_ctr = ctr[rd_idx];
   assign wr_old = ctr[wr_idx];

   always_comb begin
      nxt = wr_old;
      if (wr_taken) begin
         if (wr_old != CTR_MAX) nxt = wr_old + 1'b1;
      end else begin
         if (wr_old != '0)      nxt = wr_old - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr[i] <= WEAK_NT;
      end else if (wr_en) begin
         ctr[wr_idx] <= nxt;
      end
   end
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred import bp_pkg::*; #(
   parameter int        PC_W   = 32,
   parameter int        HIST_W = 2,
   parameter int        ADDR_W = 4,
   parameter int        CTR_W  = 2,
   parameter idx_mode_e MODE   = IDX_CONCAT,
   localparam int       GH_W   = (HIST_W > 0) ? HIST_W : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   output logic [GH_W-1:0] lk_hist,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   input  logic [GH_W-1:0] up_hist
);
   localparam int IDX_W = (MODE == IDX_CONCAT) ? (HIST_W + ADDR_W) : ADDR_W;

   initial begin : param_chk
      assert (CTR_W >= 1) else $error("CTR_W must be at least 1");
      assert (ADDR_W >= 1 && ADDR_W + 2 <= PC_W) else $error("ADDR_W out of range");
      assert (HIST_W >= 0) else $error("HIST_W must not be negative");
      assert (MODE == IDX_CONCAT || HIST_W <= ADDR_W)
         else $error("hashed mode needs HIST_W <= ADDR_W");
      assert (IDX_W <= 16) else $error("table too large");
   end

   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] up_idx;
   logic [CTR_W-1:0] lk_ctr;
   logic [CTR_W-1:0] up_ctr_old;
   logic [GH_W-1:0]  ghr;

   bp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .GH_W(GH_W),
              .IDX_W(IDX_W), .MODE(MODE)) u_lk_index (
      .pc(lk_pc), .hist(ghr), .idx(lk_idx));

   bp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .GH_W(GH_W),
              .IDX_W(IDX_W), .MODE(MODE)) u_up_index (
      .pc(up_pc), .hist(up_hist), .idx(up_idx));

   bp_ghr #(.HIST_W(HIST_W), .GH_W(GH_W)) u_ghr (
      .clk(clk), .rst_n(rst_n), .shift_en(up_valid), .bit_in(up_taken), .hist(ghr));

   bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_ctr(lk_ctr),
      .wr_en(up_valid), .wr_idx(up_idx), .wr_taken(up_taken), .wr_old(up_ctr_old));

   assign lk_taken = lk_ctr[CTR_W-1];
   assign lk_hist  = ghr;
endmodule

// File: rtl/bp_chk.sv
module bp_chk #(
   parameter int HIST_W = 2,
   parameter int GH_W   = 2,
   parameter int IDX_W  = 6,
   parameter int CTR_W  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             up_valid,
   input logic             up_taken,
   input logic [GH_W-1:0]  hist,
   input logic [IDX_W-1:0] lk_idx,
   input logic [CTR_W-1:0] lk_ctr,
   input logic [IDX_W-1:0] up_idx,
   input logic [CTR_W-1:0] up_ctr
);
   localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W-1)) - 1);

   function automatic logic [CTR_W-1:0] step_up(input logic [CTR_W-1:0] v);
      return (v == CTR_MAX) ? v : v + 1'b1;
   endfunction

   function automatic logic [CTR_W-1:0] step_dn(input logic [CTR_W-1:0] v);
      return (v == '0) ? v : v - 1'b1;
   endfunction

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (hist == '0 && lk_ctr == WEAK_NT));

   // R6
   sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken) |=>
         (lk_idx != $past(up_idx)) || (lk_ctr == step_up($past(up_ctr))));

   // R7
   sat_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken) |=>
         (lk_idx != $past(up_idx)) || (lk_ctr == step_dn($past(up_ctr))));

   generate
      if (HIST_W > 0) begin : g_hist_chk
         // R2
         hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            up_valid |=> hist[0] == $past(up_taken));

         // R2
         hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !up_valid |=> $stable(hist));
      end
   endgenerate
endmodule

bind corr_bpred bp_chk #(.HIST_W(HIST_W), .GH_W(GH_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken),
   .hist(lk_hist), .lk_idx(lk_idx), .lk_ctr(lk_ctr), .up_idx(up_idx), .up_ctr(up_ctr_old));

// File: tb/corr_bpred_tb.sv
module corr_bpred_tb;
   import bp_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic [31:0] up_pc = '0;
   logic        up_valid = 1'b0;
   logic        up_taken = 1'b0;
   logic [1:0]  up_hist = '0;
   logic        tk_c, tk_x;
   logic [1:0]  h_c, h_x;

   always #4 clk = ~clk;

   corr_bpred #(.HIST_W(2), .ADDR_W(4), .CTR_W(2), .MODE(IDX_CONCAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(tk_c), .lk_hist(h_c),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist));

   corr_bpred #(.HIST_W(2), .ADDR_W(4), .CTR_W(2), .MODE(IDX_XOR)) u_gs (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(tk_x), .lk_hist(h_x),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist));

   typedef struct {
      bit        ec;
      bit        ex;
      logic [1:0] eh;
      string     tag;
   } exp_t;

   exp_t       sb[$];
   int         checks = 0;
   int         failures = 0;
   int         mc[64];
   int         mx[16];
   logic [1:0] mg;

   function automatic int ic(logic [31:0] pc, logic [1:0] h);
      return int'({h, pc[5:2]});
   endfunction

   function automatic int ix(logic [31:0] pc, logic [1:0] h);
      return int'(pc[5:2] ^ {2'b00, h});
   endfunction

   function automatic int sat(int v, bit tk);
      if (tk) return (v == 3) ? 3 : v + 1;
      return (v == 0) ? 0 : v - 1;
   endfunction

   task automatic check(string what, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: got %0b expected %0b", what, act, exp);
      end
   endtask

   // monitor: pops expected items and compares them with the outputs
   always @(negedge clk) begin
      #2;
      while (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         check({it.tag, "/R4 concat taken"}, {1'b0, tk_c}, {1'b0, it.ec});
         check({it.tag, "/R5 xor taken"},    {1'b0, tk_x}, {1'b0, it.ex});
         check({it.tag, "/R3 hist"},         h_c,          it.eh);
         check({it.tag, "/R3 hist xor"},     h_x,          it.eh);
      end
   end

   // driver: drives one cycle, pushes expected result, then advances the model
   task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                       input bit tk, input logic [1:0] uh, input string tag);
      exp_t it;
      @(negedge clk);
      lk_pc    = lpc;
      up_valid = uv;
      up_pc    = upc;
      up_taken = tk;
      up_hist  = uh;
      it.ec  = mc[ic(lpc, mg)] >= 2;
      it.ex  = mx[ix(lpc, mg)] >= 2;
      it.eh  = mg;
      it.tag = tag;
      sb.push_back(it);
      @(posedge clk);
      if (uv) begin
         mc[ic(upc, uh)] = sat(mc[ic(upc, uh)], tk);
         mx[ix(upc, uh)] = sat(mx[ix(upc, uh)], tk);
         mg = {mg[0], tk};
      end
   endtask

   task automatic look(input logic [31:0] lpc, input string tag);
      step(lpc, 1'b0, 32'h0, 1'b0, 2'b00, tag);
   endtask

   task automatic train(input logic [31:0] lpc, input logic [31:0] upc, input bit tk,
                        input string tag);
      step(lpc, 1'b1, upc, tk, mg, tag);
   endtask

   task automatic run_all();
      for (int i = 0; i < 64; i++) mc[i] = 1;
      for (int i = 0; i < 16; i++) mx[i] = 1;
      mg = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, every lookup predicts not taken with zero history
      look(32'h0000_0000, "R1");
      look(32'h0000_003C, "R1");
      look(32'h0000_0124, "R1");
      // R2: history shifts in outcomes
      train(32'h80, 32'h80, 1'b1, "R2");
      train(32'h80, 32'h80, 1'b0, "R2");
      train(32'h80, 32'h80, 1'b1, "R2");
      look(32'h80, "R2");
      look(32'h80, "R2");
      // R6: saturate upward with a fixed captured history of zero
      for (int i = 0; i < 5; i++) step(32'h40, 1'b1, 32'h40, 1'b1, 2'b00, "R6");
      look(32'h40, "R6");
      // R7: saturate downward, history returns to zero after two not-taken
      for (int i = 0; i < 5; i++) step(32'h40, 1'b1, 32'h40, 1'b0, 2'b00, "R7");
      look(32'h40, "R7");
      step(32'h40, 1'b1, 32'h40, 1'b1, 2'b00, "R7");
      look(32'h40, "R7");
      // R9: update uses supplied history, not the live one
      step(32'h44, 1'b1, 32'h44, 1'b1, 2'b11, "R9");
      step(32'h44, 1'b1, 32'h44, 1'b1, 2'b11, "R9");
      look(32'h44, "R9");
      look(32'h50, "R9");
      // R10: same entry looked up and updated in one cycle
      train(32'h48, 32'h48, 1'b1, "R10");
      train(32'h48, 32'h48, 1'b1, "R10");
      train(32'h48, 32'h48, 1'b1, "R10");
      look(32'h48, "R10");
      // R11: low two PC bits ignored
      train(32'h4B, 32'h49, 1'b1, "R11");
      train(32'h4A, 32'h4B, 1'b1, "R11");
      look(32'h4B, "R11");
      look(32'h49, "R11");
      // R12: aliasing PCs share entries
      train(32'h0001_0048, 32'h0000_1048, 1'b0, "R12");
      train(32'h0004_0048, 32'h0004_0048, 1'b0, "R12");
      look(32'h48, "R12");
      look(32'h8000_0048, "R12");
      // R8: mixed traffic, prediction threshold against the reference model
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a, b;
         a = {26'h0, 4'($urandom_range(0, 15)), 2'b00} + 32'h100;
         b = {26'h0, 4'($urandom_range(0, 15)), 2'b00} + 32'h100;
         if (i % 7 == 0) b = a;
         if (i % 11 == 0) step(a, 1'b1, b, 1'($urandom), 2'($urandom), "R8");
         else if (i % 5 == 4) look(a, "R8");
         else train(a, b, 1'($urandom_range(0, 3) != 0), "R8");
      end
      @(negedge clk);
      up_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      bit timed_out;
      timed_out = 1'b0;
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule